// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Slice

This block is one slice of a fixed-point arithmetic column. A mode bit sets it up either as two independent signed 18x19 multipliers whose products are added or subtracted, or as a single signed 27x27 multiplier. An optional pre-adder sums the 19-bit (or 27-bit) operand with a partner operand, which folds the two mirrored taps of a symmetric filter into one multiply. The 18-bit (or 27-bit) operand can come from the input pins or from an internal bank of eight coefficient registers that is written through the same select lines.

The combined product goes into a 64-bit accumulator. The accumulator can be held, can keep adding, or can be reloaded dynamically, and it can also take in a 64-bit partial sum from the previous slice. Its raw value is driven out on a 64-bit cascade bus to the next slice, so a chain of slices forms a systolic FIR filter with no logic in between. The result port gives the accumulator shifted right by a fixed number of fraction bits. This shift either truncates or applies biased rounding.

Top module: `dual_mode_mac`

## Requirements
- R1: While reset is held and after it is released, `result` and `casc_out` are zero until the first accumulating operation.
- R2: With `wide_mode`=0 the product is sx18(op_a0[17:0])*sx19(op_b0[18:0]) + sx18(op_a1)*sx19(op_b1). The upper bits of `op_a0` and `op_b0` are ignored in this mode.
- R3: With `sub_en`=1, narrow mode subtracts the second lane product from the first, and wide mode negates the product.
- R4: With `wide_mode`=1 the product is the signed 27x27 product of `op_a0` and `op_b0`.
- R5: With `pre_en`=1, the 19-bit operand of each narrow lane (or the 27-bit `op_b0` in wide mode) is replaced by its sum with `op_d0`/`op_d1`, wrapped to that width.
- R6: With `coef_we`=1 the entry at index `coef_sel` is loaded with `coef_wdata`. With `coef_use`=1, entry `coef_sel` replaces `op_a0` (its low 18 bits in narrow mode), and in narrow mode entry (`coef_sel`+1) mod 8, low 18 bits, replaces `op_a1`.
- R7: With `acc_en`=1 and `acc_clr`=0 the product is added to the accumulator. With `acc_en`=0 the accumulator, `result` and `casc_out` hold.
- R8: With `acc_en`=1 and `acc_clr`=1 the old accumulator value is dropped, and the accumulator takes the product (plus the cascade input, if selected).
- R9: With `casc_use`=1, `casc_in` is also added, and `casc_out` always carries the unrounded 64-bit accumulator.
- R10: `result` is the accumulator shifted arithmetically right by 8 bits. With `rnd_en`=1, 2^7 is added first (biased rounding), and `rnd_en` is captured together with the operation.
- R11: An operation presented before clock edge n appears on `result` and `casc_out` just after edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_mode | input | 1 | 1: one 27x27 multiply, 0: two 18x19 multiplies |
| pre_en | input | 1 | Pre-adder enable |
| sub_en | input | 1 | Subtract second lane / negate wide product |
| coef_use | input | 1 | Take the multiplicand from the coefficient bank |
| coef_sel | input | 3 | Coefficient index for reads and writes |
| coef_we | input | 1 | Write `coef_wdata` into the bank |
| coef_wdata | input | 27 | Coefficient write data |
| op_a0 | input | 27 | Multiplicand, lane 0 / wide |
| op_a1 | input | 18 | Multiplicand, lane 1 |
| op_b0 | input | 27 | Multiplier, lane 0 / wide |
| op_b1 | input | 19 | Multiplier, lane 1 |
| op_d0 | input | 27 | Pre-adder partner, lane 0 / wide |
| op_d1 | input | 19 | Pre-adder partner, lane 1 |
| acc_en | input | 1 | Accumulator update enable |
| acc_clr | input | 1 | Drop old accumulator value on this update |
| casc_use | input | 1 | Add `casc_in` on this update |
| rnd_en | input | 1 | Biased rounding for this update |
| casc_in | input | 64 | Partial sum from the previous slice |
| casc_out | output | 64 | Raw accumulator to the next slice |
| result | output | 64 | Accumulator shifted right by 8 bits |

## Verification
Every operation passes through three registers: the input stage, the product stage and the accumulator. Its effect is therefore due just after the third rising edge after it is driven. The bench drives on a falling edge and returns the enables to idle on the next falling edge. It checks on the third falling edge, and on the second falling edge it confirms that the outputs still show the previous value. Coefficient writes take effect on the following edge, so the bench always leaves one idle cycle before an operation that reads the new entry.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  localparam int unsigned NA_W   = 18;
  localparam int unsigned NB_W   = 19;
  localparam int unsigned WD_W   = 27;
  localparam int unsigned ACC_W  = 64;
  localparam int unsigned N_COEF = 8;
  localparam int unsigned RND_K  = 8;

  typedef struct packed {
    logic wide;
    logic pre;
    logic sub;
    logic coef_use;
    logic acc_en;
    logic acc_clr;
    logic casc_use;
    logic rnd;
  } ctrl_t;
endpackage

// File: rtl/dmm_coef_bank.sv
module dmm_coef_bank #(
  parameter int unsigned N    = dmm_pkg::N_COEF,
  parameter int unsigned W    = dmm_pkg::WD_W,
  parameter int unsigned NW   = dmm_pkg::NA_W,
  localparam int unsigned SW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] raddr,
  output logic [W-1:0]  rd_main,
  output logic [NW-1:0] rd_next
);
  logic [W-1:0]  mem [N];
  logic [SW-1:0] raddr_nx;

  always_comb begin
    raddr_nx = raddr + 1'b1;
    rd_main  = mem[raddr];
    rd_next  = mem[raddr_nx][NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // R6: a write lands in the addressed entry on the next edge
  a_r6_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dmm_mul.sv
module dmm_mul #(
  parameter int unsigned NA  = dmm_pkg::NA_W,
  parameter int unsigned NB  = dmm_pkg::NB_W,
  parameter int unsigned WD  = dmm_pkg::WD_W,
  parameter int unsigned ACC = dmm_pkg::ACC_W,
  localparam int unsigned PN = NA + NB,
  localparam int unsigned PW = 2 * WD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide,
  input  logic           pre,
  input  logic           sub,
  input  logic [WD-1:0]  a0,
  input  logic [NA-1:0]  a1,
  input  logic [WD-1:0]  b0,
  input  logic [NB-1:0]  b1,
  input  logic [WD-1:0]  d0,
  input  logic [NB-1:0]  d1,
  output logic [ACC-1:0] prod_q
);
  logic [NA-1:0] la [2];
  logic [NB-1:0] lb [2];
  logic [NB-1:0] ld [2];
  logic [ACC-1:0] ln [2];

  assign la[0] = a0[NA-1:0];
  assign la[1] = a1;
  assign lb[0] = b0[NB-1:0];
  assign lb[1] = b1;
  assign ld[0] = d0[NB-1:0];
  assign ld[1] = d1;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic        [NB-1:0] bsum;
    logic signed [NA-1:0] xs;
    logic signed [NB-1:0] ys;
    logic signed [PN-1:0] pp;
    always_comb begin
      bsum  = pre ? lb[i] + ld[i] : lb[i];
      xs    = $signed(la[i]);
      ys    = $signed(bsum);
      pp    = xs * ys;
      ln[i] = {{(ACC-PN){pp[PN-1]}}, pp};
    end
  end

  logic        [WD-1:0]  wb;
  logic signed [WD-1:0]  wx, wy;
  logic signed [PW-1:0]  wp;
  logic        [ACC-1:0] wext, prod_d;

  always_comb begin
    wb   = pre ? b0 + d0 : b0;
    wx   = $signed(a0);
    wy   = $signed(wb);
    wp   = wx * wy;
    wext = {{(ACC-PW){wp[PW-1]}}, wp};
    if (wide) prod_d = sub ? ('0 - wext) : wext;
    else      prod_d = sub ? (ln[0] - ln[1]) : (ln[0] + ln[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  // R2: zero multiplicands in narrow mode give a zero product
  a_r2_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && a0[NA-1:0] == '0 && a1 == '0) |=> prod_q == '0);
  // R4: a zero multiplier in wide mode without pre-add gives zero
  a_r4_wide_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !pre && b0 == '0) |=> prod_q == '0);
endmodule

// File: rtl/dmm_acc.sv
module dmm_acc #(
  parameter int unsigned ACC = dmm_pkg::ACC_W,
  parameter int unsigned K   = dmm_pkg::RND_K
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           clr,
  input  logic           casc_use,
  input  logic           rnd,
  input  logic [ACC-1:0] prod,
  input  logic [ACC-1:0] casc_in,
  output logic [ACC-1:0] acc_q,
  output logic [ACC-1:0] result
);
  localparam logic [ACC-1:0] BIAS = {{(ACC-1){1'b0}}, 1'b1} << (K - 1);

  logic [ACC-1:0] acc_d, base, cadd, biased;
  logic           rnd_q, rnd_d;

  always_comb begin
    base   = clr ? '0 : acc_q;
    cadd   = casc_use ? casc_in : '0;
    acc_d  = en ? (base + prod + cadd) : acc_q;
    rnd_d  = en ? rnd : rnd_q;
    biased = rnd_q ? acc_q + BIAS : acc_q;
    result = $signed(biased) >>> K;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rnd_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rnd_q <= rnd_d;
    end
  end

  logic [ACC-1:0] trunc, diff;
  assign trunc = $signed(acc_q) >>> K;
  assign diff  = result - trunc;

  // R7: no update leaves the outputs unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_q) && $stable(result)));
  // R8: a reload without cascade keeps only the product
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr && !casc_use) |=> acc_q == $past(prod));
  // R10: rounding moves the result up by at most one step
  a_r10_round_step: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q |-> (diff == '0 || diff == {{(ACC-1){1'b0}}, 1'b1}));
  // R10: no round-up when the half bit is clear
  a_r10_round_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_q && !acc_q[K-1]) |-> diff == '0);
endmodule

// File: rtl/dual_mode_mac.sv
module dual_mode_mac
  import dmm_pkg::*;
#(
  parameter int unsigned NA  = NA_W,
  parameter int unsigned NB  = NB_W,
  parameter int unsigned WD  = WD_W,
  parameter int unsigned ACC = ACC_W,
  parameter int unsigned NC  = N_COEF,
  parameter int unsigned K   = RND_K,
  localparam int unsigned SW = $clog2(NC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_mode,
  input  logic           pre_en,
  input  logic           sub_en,
  input  logic           coef_use,
  input  logic [SW-1:0]  coef_sel,
  input  logic           coef_we,
  input  logic [WD-1:0]  coef_wdata,
  input  logic [WD-1:0]  op_a0,
  input  logic [NA-1:0]  op_a1,
  input  logic [WD-1:0]  op_b0,
  input  logic [NB-1:0]  op_b1,
  input  logic [WD-1:0]  op_d0,
  input  logic [NB-1:0]  op_d1,
  input  logic           acc_en,
  input  logic           acc_clr,
  input  logic           casc_use,
  input  logic           rnd_en,
  input  logic [ACC-1:0] casc_in,
  output logic [ACC-1:0] casc_out,
  output logic [ACC-1:0] result
);
  // reset: asserted at once, released after two edges
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // stage 1: input registers
  ctrl_t         ctl_d, ctl_q1, ctl_q2;
  logic [SW-1:0] sel_q1;
  logic [WD-1:0] a0_q, b0_q, d0_q;
  logic [NA-1:0] a1_q;
  logic [NB-1:0] b1_q, d1_q;

  always_comb begin
    ctl_d.wide     = wide_mode;
    ctl_d.pre      = pre_en;
    ctl_d.sub      = sub_en;
    ctl_d.coef_use = coef_use;
    ctl_d.acc_en   = acc_en;
    ctl_d.acc_clr  = acc_clr;
    ctl_d.casc_use = casc_use;
    ctl_d.rnd      = rnd_en;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q1 <= '0;
      sel_q1 <= '0;
      a0_q   <= '0;
      a1_q   <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else begin
      ctl_q1 <= ctl_d;
      sel_q1 <= coef_sel;
      a0_q   <= op_a0;
      a1_q   <= op_a1;
      b0_q   <= op_b0;
      b1_q   <= op_b1;
      d0_q   <= op_d0;
      d1_q   <= op_d1;
    end
  end

  // coefficient bank and multiplicand select
  logic [WD-1:0] cf_main;
  logic [NA-1:0] cf_next;
  logic [WD-1:0] a0_m;
  logic [NA-1:0] a1_m;

  dmm_coef_bank #(.N(NC), .W(WD), .NW(NA)) u_bank (
    .clk     (clk),
    .rst_n   (rst_i),
    .we      (coef_we),
    .waddr   (coef_sel),
    .wdata   (coef_wdata),
    .raddr   (sel_q1),
    .rd_main (cf_main),
    .rd_next (cf_next)
  );

  always_comb begin
    a0_m = ctl_q1.coef_use ? cf_main : a0_q;
    a1_m = ctl_q1.coef_use ? cf_next : a1_q;
  end

  // stage 2: products
  logic [ACC-1:0] prod_q;

  dmm_mul #(.NA(NA), .NB(NB), .WD(WD), .ACC(ACC)) u_mul (
    .clk    (clk),
    .rst_n  (rst_i),
    .wide   (ctl_q1.wide),
    .pre    (ctl_q1.pre),
    .sub    (ctl_q1.sub),
    .a0     (a0_m),
    .a1     (a1_m),
    .b0     (b0_q),
    .b1     (b1_q),
    .d0     (d0_q),
    .d1     (d1_q),
    .prod_q (prod_q)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctl_q2 <= '0;
    else        ctl_q2 <= ctl_q1;
  end

  // stage 3: accumulator and output shaping
  logic [ACC-1:0] acc_q;

  dmm_acc #(.ACC(ACC), .K(K)) u_acc (
    .clk      (clk),
    .rst_n    (rst_i),
    .en       (ctl_q2.acc_en),
    .clr      (ctl_q2.acc_clr),
    .casc_use (ctl_q2.casc_use),
    .rnd      (ctl_q2.rnd),
    .prod     (prod_q),
    .casc_in  (casc_in),
    .acc_q    (acc_q),
    .result   (result)
  );

  assign casc_out = acc_q;

  // R1: outputs are zero while the internal reset is held
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_i |-> (casc_out == '0 && result == '0));
  // R11: with no update in flight two stages back, the cascade bus holds
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_i)
    !ctl_q2.acc_en |=> $stable(casc_out));
endmodule

// File: tb/test_dual_mode_mac.sv
module test_dual_mode_mac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode, pre_en, sub_en, coef_use, coef_we;
  logic [2:0]  coef_sel;
  logic [26:0] coef_wdata, op_a0, op_b0, op_d0;
  logic [17:0] op_a1;
  logic [18:0] op_b1, op_d1;
  logic        acc_en, acc_clr, casc_use, rnd_en;
  logic [63:0] casc_in, casc_out, result;

  always #2.5 clk = ~clk;

  dual_mode_mac i_dual_mode_mac (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .pre_en(pre_en),
    .sub_en(sub_en), .coef_use(coef_use), .coef_sel(coef_sel),
    .coef_we(coef_we), .coef_wdata(coef_wdata), .op_a0(op_a0),
    .op_a1(op_a1), .op_b0(op_b0), .op_b1(op_b1), .op_d0(op_d0),
    .op_d1(op_d1), .acc_en(acc_en), .acc_clr(acc_clr),
    .casc_use(casc_use), .rnd_en(rnd_en), .casc_in(casc_in),
    .casc_out(casc_out), .result(result)
  );

  int     n_run = 0, n_fail = 0;
  bit     done = 0;
  longint m_acc = 0;
  bit     m_rnd = 0;
  longint m_bank [8];

  function automatic longint sx(longint v, int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  function automatic longint model_prod();
    longint a, b, x0, x1, y0, y1;
    if (wide_mode) begin
      a = coef_use ? m_bank[coef_sel] : longint'(op_a0);
      b = pre_en ? longint'(op_b0) + longint'(op_d0) : longint'(op_b0);
      a = sx(a, 27);
      b = sx(b, 27);
      return sub_en ? -(a * b) : a * b;
    end
    x0 = sx(coef_use ? m_bank[coef_sel] : longint'(op_a0), 18);
    x1 = sx(coef_use ? m_bank[3'(coef_sel + 3'd1)] : longint'(op_a1), 18);
    y0 = sx(pre_en ? longint'(op_b0) + longint'(op_d0) : longint'(op_b0), 19);
    y1 = sx(pre_en ? longint'(op_b1) + longint'(op_d1) : longint'(op_b1), 19);
    return sub_en ? x0 * y0 - x1 * y1 : x0 * y0 + x1 * y1;
  endfunction

  function automatic longint model_res();
    longint v;
    v = m_rnd ? m_acc + 64'sd128 : m_acc;
    return v >>> 8;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    wide_mode = 0; pre_en = 0; sub_en = 0; coef_use = 0; coef_we = 0;
    coef_sel = 0; coef_wdata = 0; op_a0 = 0; op_a1 = 0; op_b0 = 0;
    op_b1 = 0; op_d0 = 0; op_d1 = 0; acc_en = 0; acc_clr = 0;
    casc_use = 0; rnd_en = 0; casc_in = 0;
  endtask

  // drive an operation at a falling edge, check three edges later
  task automatic fire(string tag);
    longint old_acc, p;
    old_acc = m_acc;
    p = model_prod();
    if (acc_en) begin
      m_acc = (acc_clr ? 0 : m_acc) + p + (casc_use ? longint'(casc_in) : 0);
      m_rnd = rnd_en;
    end
    @(negedge clk);
    acc_en = 0; coef_we = 0;
    @(negedge clk);
    chk({tag, " R11 not early"}, casc_out, old_acc);
    @(negedge clk);
    chk({tag, " casc_out"}, casc_out, m_acc);
    chk({tag, " result"}, result, model_res());
  endtask

  task automatic write_coef(int idx, logic [26:0] v);
    coef_we = 1; coef_sel = 3'(idx); coef_wdata = v; acc_en = 0;
    m_bank[idx] = longint'(v);
    @(negedge clk);
    coef_we = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 result after reset", result, 64'd0);
    chk("R1 casc_out after reset", casc_out, 64'd0);
  endtask

  task automatic t_dual();
    idle_inputs(); acc_en = 1; acc_clr = 1;
    op_a0 = 27'h404_0003; op_b0 = 27'h408_0005; op_a1 = 18'h3FFFE; op_b1 = 19'd7;
    fire("R2 dual upper bits ignored");
    idle_inputs(); acc_en = 1; acc_clr = 1;
    op_a0 = 27'h002_0000; op_b0 = 27'h004_0000; op_a1 = 18'h1FFFF; op_b1 = 19'h3FFFF;
    fire("R2 dual extremes");
  endtask

  task automatic t_sub();
    idle_inputs(); acc_en = 1; acc_clr = 1; sub_en = 1;
    op_a0 = 27'd100; op_b0 = 27'd3; op_a1 = 18'd7; op_b1 = 19'd50;
    fire("R3 dual subtract");
    idle_inputs(); acc_en = 1; acc_clr = 1; sub_en = 1; wide_mode = 1;
    op_a0 = 27'h3FF_FFFF; op_b0 = 27'd1000;
    fire("R3 wide negate");
  endtask

  task automatic t_wide();
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1;
    op_a0 = 27'h400_0000; op_b0 = 27'h400_0000;
    fire("R4 wide min*min");
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1;
    op_a0 = 27'h123_4567; op_b0 = 27'h7ED_CBA9;
    fire("R4 wide mixed sign");
  endtask

  task automatic t_pre();
    idle_inputs(); acc_en = 1; acc_clr = 1; pre_en = 1;
    op_a0 = 27'd5; op_b0 = 27'd10; op_d0 = 27'd20;
    op_a1 = 18'd3; op_b1 = 19'h3FFFF; op_d1 = 19'd1;
    fire("R5 narrow pre-add with wrap");
    idle_inputs(); acc_en = 1; acc_clr = 1; pre_en = 1; wide_mode = 1;
    op_a0 = 27'd9; op_b0 = 27'h3FF_FFFF; op_d0 = 27'd2;
    fire("R5 wide pre-add with wrap");
  endtask

  task automatic t_coef();
    idle_inputs();
    for (int i = 0; i < 8; i++) write_coef(i, 27'(i * 1111 + 27'h3F_0000));
    idle_inputs(); acc_en = 1; acc_clr = 1; coef_use = 1; coef_sel = 3'd7;
    op_a0 = 27'd999; op_a1 = 18'd999; op_b0 = 27'd3; op_b1 = 19'd5;
    fire("R6 narrow bank index wrap");
    idle_inputs(); acc_en = 1; acc_clr = 1; coef_use = 1; coef_sel = 3'd3;
    wide_mode = 1; op_b0 = 27'h7FF_FFFD;
    fire("R6 wide bank entry");
  endtask

  task automatic t_accum();
    idle_inputs(); acc_en = 1; acc_clr = 1; op_a0 = 27'd1000; op_b0 = 27'd1000;
    fire("R8 reload");
    idle_inputs(); acc_en = 1; op_a0 = 27'd300; op_b0 = 27'h7FF_FFFF;
    fire("R7 accumulate");
    idle_inputs(); acc_en = 0; op_a0 = 27'd77; op_b0 = 27'd77; rnd_en = 1;
    fire("R7 hold when disabled");
    idle_inputs(); acc_en = 1; acc_clr = 1; op_a0 = 27'd2; op_b0 = 27'd2;
    fire("R8 reload drops history");
  endtask

  task automatic t_casc();
    idle_inputs(); acc_en = 1; acc_clr = 1; casc_use = 1;
    casc_in = 64'h0123_4567_89AB_CDEF; op_a0 = 27'd4; op_b0 = 27'd6;
    fire("R9 cascade reload");
    idle_inputs(); acc_en = 1; casc_use = 1; casc_in = 64'hFFFF_FFFF_FFFF_F000;
    fire("R9 cascade accumulate");
  endtask

  task automatic t_round();
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1; rnd_en = 1;
    op_a0 = 27'd383; op_b0 = 27'd1;
    fire("R10 round below half");
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1; rnd_en = 1;
    op_a0 = 27'd384; op_b0 = 27'd1;
    fire("R10 round at half");
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1; rnd_en = 1;
    op_a0 = 27'd384; op_b0 = 27'h7FF_FFFF;
    fire("R10 round negative");
    idle_inputs(); acc_en = 1; acc_clr = 1; wide_mode = 1; rnd_en = 0;
    op_a0 = 27'd384; op_b0 = 27'h7FF_FFFF;
    fire("R10 truncate negative");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_bank[i] = 0;
    idle_inputs();
    rst_n = 0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dual();
    t_sub();
    t_wide();
    t_pre();
    t_coef();
    t_accum();
    t_casc();
    t_round();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule